// File: doc/BRIEF.md
# SPI Mode-3 Register Target

This block lets an SPI host read and write a bank of byte-wide registers. The host pulls the select line low, clocks a one-bit direction flag (1 = write, 0 = read) and a 15-bit register address, MSB first, and then moves any number of data bytes, MSB first. The clock idles high. Input bits are taken on the clock's rising edge and the returned bit changes on its falling edge. After every complete data byte the register address steps by one, so a single frame can cover a run of consecutive registers in either direction.

The bus pins are sampled with the block's own system clock through a synchronizer. Clock edges are found on the synchronized copies, so the SPI clock may run at any rate well below the system clock and may stop for any length of time. On the user side a register-bank port carries the address, the write data and a one-cycle write strobe. The bank returns read data and two flags: one marks the address as populated and one marks it as writable. Raising the select line at any point abandons the frame, and a byte that was only partly received never reaches the bank.

Top module: `spi_regtarget`

## Requirements
- R1: After reset, with the select line high, `bus_miso` and `bus_miso_oe` are 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: While `bus_sel_n` is high, activity on `bus_clk` and `bus_mosi` produces no write strobe, and `bus_miso_oe` and `bus_miso` stay 0. The next frame is decoded from its first bit.
- R3: A frame whose first bit is 1 is a write. When the 8th data bit is captured, `reg_we` pulses for exactly one system cycle. During that pulse `reg_addr` holds the 15-bit address received MSB first and `reg_wdata` holds the byte received MSB first.
- R4: A frame whose first bit is 0 is a read. The byte at the received address is put on `bus_miso` MSB first, starting at the falling edge that follows the last address bit, so the host samples data bit 7 on the 17th rising edge of the frame.
- R5: During the header, the level the host samples on `bus_miso` at rising edge k (k = 1..15, counting from 0) equals the MOSI bit taken at rising edge k-1. At rising edge 0 it is 0.
- R6: In a write frame, each further byte goes to the next address. The address steps by one in the cycle after each write strobe.
- R7: In a read frame, each further byte is read from the next address with no gap in the bit stream.
- R8: A read from an address whose `reg_present` is 0 returns 0x00, whatever `reg_rdata` carries.
- R9: A byte sent to an address whose `reg_wr_ok` is 0 produces no strobe. The burst still moves on to the next address.
- R10: Raising `bus_sel_n` in the header or part way through a data byte causes no register change. The next frame is decoded from its first bit.
- R11: `bus_clk` may be held high between bits for any number of cycles with no loss of frame state.
- R12: The address steps from 0x7FFF to 0x0000 during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | SPI select, active low |
| bus_clk | input | 1 | SPI clock from the host, idles high |
| bus_mosi | input | 1 | Serial data from the host |
| bus_miso | output | 1 | Serial data to the host, 0 while not driven |
| bus_miso_oe | output | 1 | High while `bus_miso` is actively driven |
| reg_addr | output | 15 | Register address presented to the bank |
| reg_wdata | output | 8 | Write data for the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank for `reg_addr` |
| reg_present | input | 1 | `reg_addr` is a populated register |
| reg_wr_ok | input | 1 | `reg_addr` accepts writes |

## Verification
The assertions rely on three things about the inputs. Each SPI clock phase and each select-line phase lasts several system cycles longer than the synchronizer depth. The select line does not rise within a few cycles of the rising clock edge that completes a byte. The bank's `reg_present` and `reg_wr_ok` are fixed for each address. The stimulus keeps to these by holding every SPI clock phase for eight system cycles and by moving the select line only a full half period away from any clock edge. It also tests pauses by holding the clock high for hundreds of cycles. The bank model reports flags that depend only on the address.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;

    // Position inside a frame: header (flag + address), then data of one direction
    typedef enum logic [1:0] {
        PH_HEAD  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } spi_rt_phase_e;

endpackage

// File: rtl/spi_rt_sync.sv
module spi_rt_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_rt_frame.sv
module spi_rt_frame
    import spi_rt_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_present,
    input  logic              reg_wr_ok,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              miso_bit
);

    localparam int HDR_BITS = ADDR_W + 1;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam int BIT_W    = $clog2(DATA_W);

    typedef struct packed {
        spi_rt_phase_e     phase;
        logic              wr;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] wdata;
        logic              last;
        logic              miso;
        logic              we;
        logic              inc;
        logic              fetch;
        logic              sclk_p;
    } st_t;

    function automatic st_t idle_state();
        st_t s;
        s        = '0;
        s.phase  = PH_HEAD;
        s.sclk_p = 1'b1;
        return s;
    endfunction

    st_t  st_d, st_q;
    logic rise, fall;

    always_comb begin
        rise      = sclk_s & ~st_q.sclk_p;
        fall      = ~sclk_s & st_q.sclk_p;
        st_d      = st_q;
        st_d.we   = 1'b0;
        if (sel_n_s) begin
            // deselected: frame state cleared, a pending step still lands
            st_d        = idle_state();
            st_d.wdata  = st_q.wdata;
            st_d.addr   = st_q.inc ? st_q.addr + 1'b1 : st_q.addr;
        end else begin
            if (st_q.inc) begin
                st_d.addr  = st_q.addr + 1'b1;
                st_d.inc   = 1'b0;
                st_d.fetch = (st_q.phase == PH_READ);
            end
            if (st_q.fetch) begin
                st_d.tx    = reg_present ? reg_rdata : '0;
                st_d.fetch = 1'b0;
            end
            if (rise) begin
                unique case (st_q.phase)
                    PH_HEAD: begin
                        st_d.last = mosi_s;
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.cnt == '0) st_d.wr   = mosi_s;
                        else                st_d.addr = {st_q.addr[ADDR_W-2:0], mosi_s};
                        if (st_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            st_d.phase = st_q.wr ? PH_WRITE : PH_READ;
                            st_d.fetch = ~st_q.wr;
                            st_d.bitc  = '0;
                        end
                    end
                    PH_WRITE: begin
                        st_d.rx   = {st_q.rx[DATA_W-2:0], mosi_s};
                        st_d.bitc = st_q.bitc + 1'b1;
                        if (st_q.bitc == BIT_W'(DATA_W - 1)) begin
                            st_d.we    = reg_wr_ok;
                            st_d.wdata = {st_q.rx[DATA_W-2:0], mosi_s};
                            st_d.inc   = 1'b1;
                            st_d.bitc  = '0;
                        end
                    end
                    default: begin
                        st_d.bitc = st_q.bitc + 1'b1;
                        if (st_q.bitc == BIT_W'(DATA_W - 1)) begin
                            st_d.inc  = 1'b1;
                            st_d.bitc = '0;
                        end
                    end
                endcase
            end else if (fall) begin
                unique case (st_q.phase)
                    PH_HEAD:  st_d.miso = (st_q.cnt == '0) ? 1'b0 : st_q.last;
                    PH_WRITE: st_d.miso = 1'b0;
                    default: begin
                        st_d.miso = st_q.tx[DATA_W-1];
                        st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b0};
                    end
                endcase
            end
        end
        st_d.sclk_p = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= idle_state();
        else        st_q <= st_d;
    end

    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.wdata;
    assign reg_we    = st_q.we;
    assign miso_bit  = st_q.miso;

endmodule

// File: rtl/spi_regtarget.sv
module spi_regtarget #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_clk,
    input  logic              bus_mosi,
    output logic              bus_miso,
    output logic              bus_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_present,
    input  logic              reg_wr_ok
);

    localparam int PINS = 3;

    logic [PINS-1:0] pins_s;
    logic            miso_bit;

    // order {select, clock, data}; select and clock idle high
    spi_rt_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({bus_sel_n, bus_clk, bus_mosi}),
        .sync_o (pins_s)
    );

    spi_rt_frame #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_s    (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .reg_rdata  (reg_rdata),
        .reg_present(reg_present),
        .reg_wr_ok  (reg_wr_ok),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .miso_bit   (miso_bit)
    );

    assign bus_miso_oe = ~bus_sel_n;
    assign bus_miso    = bus_miso_oe & miso_bit;

endmodule

// File: rtl/spi_regtarget_chk.sv
module spi_regtarget_chk #(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              reg_wr_ok
);

    localparam int QUIET = SYNC_STAGES + 6;

    int unsigned idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                idle_q <= 0;
        else if (!bus_sel_n)       idle_q <= 0;
        else if (idle_q < QUIET)   idle_q <= idle_q + 1;
    end

    // R3: strobe lasts one cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6: address moves on right after a strobe
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

    // R9: strobes only toward writable registers
    a_r9_write_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_wr_ok);

    // R2: no strobe once deselected long enough
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q >= QUIET) |-> !reg_we);

endmodule

bind spi_regtarget spi_regtarget_chk #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel_n(bus_sel_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wr_ok(reg_wr_ok)
);

// File: tb/test_spi_regtarget.sv
module test_spi_regtarget;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ncs = 1'b1, sck = 1'b1, mosi = 1'b0;
    logic        bus_miso, bus_miso_oe, reg_we, reg_present, reg_wr_ok;
    logic [14:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    always #2 clk = ~clk;

    spi_regtarget i_spi_regtarget (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(ncs), .bus_clk(sck), .bus_mosi(mosi),
        .bus_miso(bus_miso), .bus_miso_oe(bus_miso_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .reg_present(reg_present), .reg_wr_ok(reg_wr_ok));

    int n_run = 0, n_fail = 0;

    // bank: 0x0000-0x000F read/write, 0x0010-0x0013 read-only 0xC0|low bits, 0x7FFF read-only 0xA5
    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];

    assign reg_present = (reg_addr < 15'd20) || (reg_addr == 15'h7FFF);
    assign reg_wr_ok   = (reg_addr < 15'd16);
    assign reg_rdata   = (reg_addr < 15'd16) ? mem[reg_addr[3:0]] :
                         (reg_addr < 15'd20) ? (8'hC0 | {6'd0, reg_addr[1:0]}) :
                         (reg_addr == 15'h7FFF) ? 8'hA5 : 8'h5A;

    always @(posedge clk) if (reg_we) mem[reg_addr[3:0]] <= reg_wdata;

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        if (a < 15'd16)      return exp_mem[a[3:0]];
        if (a < 15'd20)      return 8'hC0 | {6'd0, a[1:0]};
        if (a == 15'h7FFF)   return 8'hA5;
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected strobes, in order
    logic [14:0] ew_a [$];
    logic [7:0]  ew_d [$];

    always @(negedge clk) if (rst_n) begin
        if (reg_we) begin
            if (ew_a.size() == 0) begin
                check(1'b0, "R9 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [14:0] ea;
                logic [7:0]  ed;
                ea = ew_a.pop_front();
                ed = ew_d.pop_front();
                check(reg_addr == ea && reg_wdata == ed, "R3 strobe addr/data",
                      {reg_addr, reg_wdata}, {ea, ed});
            end
        end
        if (ncs && (bus_miso_oe || bus_miso))
            check(1'b0, "R2 miso driven while deselected", {bus_miso_oe, bus_miso}, 0);
    end

    logic       txb [$];
    logic       rxb [$];
    logic [7:0] wq  [$];

    task automatic frame(input bit wr, input logic [14:0] a, input int nrd,
                         input int cut, input int pause_at, input int pause_len);
        int total;
        txb.delete();
        rxb.delete();
        txb.push_back(wr);
        for (int i = 14; i >= 0; i--) txb.push_back(a[i]);
        if (wr) begin
            foreach (wq[j]) for (int i = 7; i >= 0; i--) txb.push_back(wq[j][i]);
        end else begin
            for (int i = 0; i < nrd * 8; i++) txb.push_back(i[0]);
        end
        total = (cut >= 0) ? cut : txb.size();
        @(negedge clk);
        ncs = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            sck  = 1'b0;
            mosi = txb[i];
            repeat (HP) @(negedge clk);
            rxb.push_back(bus_miso);
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            if (i == pause_at) repeat (pause_len) @(negedge clk);
        end
        ncs = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    task automatic check_echo(input string req);
        logic ok;
        ok = (rxb[0] == 1'b0);
        for (int k = 1; k < 16; k++) if (rxb[k] !== txb[k-1]) ok = 1'b0;
        check(ok, req, 0, 1);
    endtask

    task automatic wr_burst(input logic [14:0] a, input int pause_at, input int pause_len);
        foreach (wq[j]) begin
            logic [14:0] aa;
            aa = a + 15'(j);
            if (aa < 15'd16) begin
                ew_a.push_back(aa);
                ew_d.push_back(wq[j]);
                exp_mem[aa[3:0]] = wq[j];
            end
        end
        frame(1'b1, a, 0, -1, pause_at, pause_len);
        check(ew_a.size() == 0, "R3 strobes seen for full bytes", ew_a.size(), 0);
    endtask

    task automatic rd_burst(input logic [14:0] a, input int n, input string req,
                            input int pause_at, input int pause_len);
        frame(1'b0, a, n, -1, pause_at, pause_len);
        for (int j = 0; j < n; j++) begin
            logic [7:0] got, exp;
            for (int i = 0; i < 8; i++) got[7-i] = rxb[16 + 8*j + i];
            exp = model_rd(a + 15'(j));
            check(got == exp, req, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]     = 8'(i * 17);
            exp_mem[i] = 8'(i * 17);
        end
        repeat (5) @(negedge clk);
        // R1 reset state
        check(bus_miso == 1'b0, "R1 miso at reset", bus_miso, 0);
        check(bus_miso_oe == 1'b0, "R1 oe at reset", bus_miso_oe, 0);
        check(reg_we == 1'b0, "R1 strobe at reset", reg_we, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(reg_addr == 15'd0, "R1 address after reset", reg_addr, 0);

        // R2 bus activity while deselected
        for (int i = 0; i < 24; i++) begin
            sck = ~sck; mosi = i[1];
            repeat (HP) @(negedge clk);
            check(bus_miso_oe == 1'b0 && bus_miso == 1'b0, "R2 outputs while deselected",
                  {bus_miso_oe, bus_miso}, 0);
            if (i == 0) i = i;
        end
        sck = 1'b1;
        repeat (HP) @(negedge clk);
        rd_burst(15'h0003, 1, "R2 first frame after idle activity", -1, 0);

        // R3, R5 single write; R4 single read
        wq = '{8'h3C};
        wr_burst(15'h0002, -1, 0);
        check_echo("R5 header echo on write");
        rd_burst(15'h0002, 1, "R4 single read", -1, 0);
        check_echo("R5 header echo on read");

        // R6 burst write, R7 burst read
        wq = '{8'h81, 8'h42, 8'hE7, 8'h18};
        wr_burst(15'h0008, -1, 0);
        rd_burst(15'h0007, 6, "R7 burst read", -1, 0);

        // R8 unused reads
        rd_burst(15'h0100, 1, "R8 unused address reads zero", -1, 0);
        rd_burst(15'h0012, 4, "R8 burst into unused space", -1, 0);

        // R9 read-only target and a burst crossing into it
        wq = '{8'hFF};
        wr_burst(15'h0011, -1, 0);
        rd_burst(15'h0011, 1, "R9 read-only register unchanged", -1, 0);
        wq = '{8'h6B, 8'h00};
        wr_burst(15'h000F, -1, 0);
        rd_burst(15'h000F, 2, "R9 burst across writable edge", -1, 0);

        // R10 aborts: mid data byte, then mid header
        wq = '{8'h99};
        frame(1'b1, 15'h0004, 0, 16 + 5, -1, 0);
        rd_burst(15'h0004, 1, "R10 partial byte leaves register", -1, 0);
        frame(1'b1, 15'h0006, 0, 7, -1, 0);
        rd_burst(15'h0006, 1, "R10 fresh frame after header abort", -1, 0);

        // R11 clock held high mid header and mid data
        wq = '{8'h5A, 8'hA6};
        wr_burst(15'h0001, 20, 300);
        rd_burst(15'h0001, 2, "R11 read with pause in header", 9, 400);

        // R12 address wrap
        rd_burst(15'h7FFF, 2, "R12 read wraps to zero", -1, 0);
        wq = '{8'h11, 8'hC3};
        wr_burst(15'h7FFF, -1, 0);
        rd_burst(15'h0000, 1, "R12 write after wrap", -1, 0);

        check(ew_a.size() == 0, "R6 all expected strobes seen", ew_a.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule